// File: doc/BRIEF.md
# Region Wait-State Cycle Calculator

This block gives the number of bus cycles that one transfer takes. Its inputs are the transfer address, the access width, a hint that the access continues a sequential burst, and the programmed wait fields. The address space has two parts. The external part has four wait sets. Each set has a programmable first-access cost and a programmable burst cost, and its data path is 16 bits wide. The internal part has eight regions. Most of them answer in one cycle, and one of them has a programmable wait.

The cycle count is combinational and is ready in the same cycle as the address. One bit of state is kept. An idle bus cycle aimed at the external part sets an idle marker. While the marker is set, the next transfer pays the first-access cost. The next read or write clears the marker. The wait fields come in on ports, so the logic that programs them stays outside this block.

Top module: `wait_cycle_calc`

## Requirements
- R1: Address bit 27 high selects the external cost. Bit 27 low selects the internal cost, and the internal region is taken from bits 26:24.
- R2: In the external part, bits 26:25 pick wait set k. Its non-sequential field is `nwait_i[2k+1:2k]`, and codes 0, 1, 2 and 3 cost 5, 4, 3 and 9 cycles. A byte or half access that is not sequential costs exactly that.
- R3: The burst bit of set k is `swait_i[k]`. When it is high, the sequential cost is 3 for set 0, 5 for set 1 and 9 for set 2. When it is low, the sequential cost is 2. Set 3 ignores its burst bit and uses its non-sequential cost as its sequential cost.
- R4: Size is coded 0 for byte, 1 for half and 2 for word. An external sequential word costs twice the sequential cost. An external non-sequential word costs the non-sequential cost plus the sequential cost.
- R5: An external access whose address bits 16:1 are all zero is priced as non-sequential, even when `seq_i` is high.
- R6: While `idle_flag_o` is high, every external access is priced as non-sequential.
- R7: Internal region 2 costs 16 minus `ram_wait_i` cycles. It costs twice that for a word access.
- R8: Internal regions 5 and 6 cost 1 cycle, or 2 for a word access. Regions 0, 1, 3, 4 and 7 cost 1 cycle at every size.
- R9: `idle_flag_o` is low after reset. It goes high on the clock edge after `idle_i` is asserted with address bit 27 high. `idle_i` with bit 27 low leaves it unchanged. It goes low on the clock edge after `acc_i` is asserted.
- R10: When `idle_i` and `acc_i` are asserted in the same cycle, the flag ends low. The access in that cycle is priced with the flag value it had before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 28 | Transfer address |
| size_i | input | 2 | Access width: 0 byte, 1 half, 2 word |
| seq_i | input | 1 | Sequential-access hint |
| acc_i | input | 1 | A read or write takes place this cycle |
| idle_i | input | 1 | Idle bus cycle toward addr_i |
| nwait_i | input | 8 | Non-sequential codes, 2 bits per wait set |
| swait_i | input | 4 | Burst bits, 1 per wait set |
| ram_wait_i | input | 4 | Wait field for internal region 2 |
| cycles_o | output | 6 | Cycle count for the current transfer |
| idle_flag_o | output | 1 | Idle marker state |

## Verification
An idle-marker update and a priced access can fall in the same cycle. The bench provokes this by driving `idle_i` and `acc_i` together with an external address. It first does this with the marker low, and then again with the marker already set. In each case it checks that the count for that cycle uses the old marker value (R10), and that the marker is low afterwards. A page-boundary address combined with a set marker checks that the two causes of non-sequential pricing do not interfere with each other.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int CYC_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  // first-access cost from a 2-bit wait code
  function automatic logic [CYC_W-1:0] n_cost(input logic [1:0] code);
    case (code)
      2'd0:    n_cost = CYC_W'(5);
      2'd1:    n_cost = CYC_W'(4);
      2'd2:    n_cost = CYC_W'(3);
      default: n_cost = CYC_W'(9);
    endcase
  endfunction

  // long burst cost of a set when its burst bit is high
  function automatic logic [CYC_W-1:0] s_long(input int set);
    case (set)
      0:       s_long = CYC_W'(3);
      1:       s_long = CYC_W'(5);
      default: s_long = CYC_W'(9);
    endcase
  endfunction
endpackage

// File: rtl/ext_wait_calc.sv
module ext_wait_calc
  import wsc_pkg::*;
#(
  parameter int SETS = 4,
  localparam int SEL_W = $clog2(SETS)
) (
  input  logic [SEL_W-1:0]  set_i,
  input  logic [1:0]        size_i,
  input  logic              seq_i,
  input  logic              page_i,
  input  logic              idle_flag_i,
  input  logic [2*SETS-1:0] nwait_i,
  input  logic [SETS-1:0]   swait_i,
  output logic [CYC_W-1:0]  cyc_o
);
  logic [CYC_W-1:0] n_tab [SETS];
  logic [CYC_W-1:0] s_tab [SETS];
  logic unused_sw_last;

  for (genvar k = 0; k < SETS; k++) begin : g_set
    assign n_tab[k] = n_cost(nwait_i[2*k +: 2]);
    if (k == SETS-1) begin : g_last
      // last set reuses its first-access cost for bursts
      assign s_tab[k] = n_tab[k];
    end else begin : g_norm
      assign s_tab[k] = swait_i[k] ? s_long(k) : CYC_W'(2);
    end
  end
  assign unused_sw_last = swait_i[SETS-1];

  logic [CYC_W-1:0] n_sel, s_sel;
  logic             is_seq, is_word;

  assign n_sel   = n_tab[set_i];
  assign s_sel   = s_tab[set_i];
  assign is_word = (size_i == SZ_WORD);
  assign is_seq  = seq_i && !page_i && !idle_flag_i;

  always_comb begin
    if (is_seq) cyc_o = is_word ? (s_sel << 1) : s_sel;
    else        cyc_o = is_word ? (n_sel + s_sel) : n_sel;
  end
endmodule

// File: rtl/int_wait_calc.sv
module int_wait_calc
  import wsc_pkg::*;
#(
  parameter int RW_W = 4
) (
  input  logic [2:0]       region_i,
  input  logic [1:0]       size_i,
  input  logic [RW_W-1:0]  ram_wait_i,
  output logic [CYC_W-1:0] cyc_o
);
  localparam int RW_MAX = (1 << RW_W) - 1;

  logic [CYC_W-1:0] base;
  logic             wide16;

  always_comb begin
    base   = CYC_W'(1);
    wide16 = 1'b0;
    case (region_i)
      3'd2: begin
        base   = CYC_W'(1 + RW_MAX) - CYC_W'(ram_wait_i);
        wide16 = 1'b1;
      end
      3'd5, 3'd6: wide16 = 1'b1;
      default: ;
    endcase
    cyc_o = (wide16 && size_i == SZ_WORD) ? (base << 1) : base;
  end
endmodule

// File: rtl/idle_tracker.sv
module idle_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic ext_i,
  input  logic acc_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (acc_i)          flag_q <= 1'b0;  // access wins over idle
    else if (idle_i && ext_i) flag_q <= 1'b1;
  end
  assign flag_o = flag_q;

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !flag_o);
  p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && ext_i && !acc_i) |=> flag_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !(idle_i && ext_i)) |=> $stable(flag_o));
endmodule

// File: rtl/wait_cycle_calc.sv
module wait_cycle_calc
  import wsc_pkg::*;
#(
  parameter int SETS = 4,
  parameter int RW_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [27:0]         addr_i,
  input  logic [1:0]          size_i,
  input  logic                seq_i,
  input  logic                acc_i,
  input  logic                idle_i,
  input  logic [2*SETS-1:0]   nwait_i,
  input  logic [SETS-1:0]     swait_i,
  input  logic [RW_W-1:0]     ram_wait_i,
  output logic [CYC_W-1:0]    cycles_o,
  output logic                idle_flag_o
);
  logic             is_ext, page;
  logic [2:0]       region;
  logic [CYC_W-1:0] ext_cyc, int_cyc;
  logic             unused_addr;

  assign is_ext      = addr_i[27];
  assign region      = addr_i[26:24];
  assign page        = (addr_i[16:1] == '0);
  assign unused_addr = ^{addr_i[23:17], addr_i[0]};

  idle_tracker u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (idle_i),
    .ext_i  (is_ext),
    .acc_i  (acc_i),
    .flag_o (idle_flag_o)
  );

  ext_wait_calc #(.SETS(SETS)) u_ext (
    .set_i       (addr_i[26:25]),
    .size_i      (size_i),
    .seq_i       (seq_i),
    .page_i      (page),
    .idle_flag_i (idle_flag_o),
    .nwait_i     (nwait_i),
    .swait_i     (swait_i),
    .cyc_o       (ext_cyc)
  );

  int_wait_calc #(.RW_W(RW_W)) u_int (
    .region_i   (region),
    .size_i     (size_i),
    .ram_wait_i (ram_wait_i),
    .cyc_o      (int_cyc)
  );

  assign cycles_o = is_ext ? ext_cyc : int_cyc;

  p_int_flat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i[27] && !(addr_i[26:24] inside {3'd2, 3'd5, 3'd6})) |-> cycles_o == 1);
  p_ext_floor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[27] |-> cycles_o >= 2);
  p_ram_even_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i[27] && addr_i[26:24] == 3'd2 && size_i == 2'd2) |-> !cycles_o[0]);
endmodule

// File: tb/tb_wait_cycle_calc.sv
`timescale 1ns/1ps
module tb_wait_cycle_calc;
  logic        clk = 0, rst_ni = 0;
  logic [27:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        seq_i = 0, acc_i = 0, idle_i = 0;
  logic [7:0]  nwait_i = '0;
  logic [3:0]  swait_i = '0, ram_wait_i = '0;
  logic [5:0]  cycles_o;
  logic        idle_flag_o;

  int n_chk = 0, n_fail = 0;
  bit exp_flag = 0;

  typedef struct { int cyc; bit flag; string tag; } item_t;
  item_t q[$];
  event ev;

  always #2.5 clk = ~clk;

  wait_cycle_calc dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .size_i(size_i),
    .seq_i(seq_i), .acc_i(acc_i), .idle_i(idle_i), .nwait_i(nwait_i),
    .swait_i(swait_i), .ram_wait_i(ram_wait_i), .cycles_o(cycles_o),
    .idle_flag_o(idle_flag_o)
  );

  function automatic int model(bit [27:0] a, bit [1:0] sz, bit sq, bit fl);
    int k, n, s, w;
    bit ns, word;
    word = (sz == 2);
    if (a[27]) begin
      k = a[26:25];
      case (nwait_i[2*k +: 2]) 0: n = 5; 1: n = 4; 2: n = 3; default: n = 9; endcase
      if (k == 3) s = n;
      else if (swait_i[k]) s = (k == 0) ? 3 : (k == 1) ? 5 : 9;
      else s = 2;
      ns = !sq || (a[16:1] == 0) || fl;
      if (!ns) return word ? 2*s : s;
      return word ? n + s : n;
    end
    case (a[26:24])
      2: begin w = 16 - ram_wait_i; return word ? 2*w : w; end
      5, 6: return word ? 2 : 1;
      default: return 1;
    endcase
  endfunction

  task automatic step(bit [27:0] a, bit [1:0] sz, bit sq, bit ac, bit id, string tag);
    item_t it;
    @(negedge clk);
    addr_i = a; size_i = sz; seq_i = sq; acc_i = ac; idle_i = id;
    it.cyc = model(a, sz, sq, exp_flag); it.flag = exp_flag; it.tag = tag;
    q.push_back(it);
    -> ev;
    @(posedge clk);
    if (ac) exp_flag = 0;
    else if (id && a[27]) exp_flag = 1;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(ev);
      #1;
      it = q.pop_front();
      n_chk++;
      if (cycles_o !== 6'(it.cyc) || idle_flag_o !== it.flag) begin
        n_fail++;
        $display("FAIL %s: cycles=%0d flag=%0b expected cycles=%0d flag=%0b",
                 it.tag, cycles_o, idle_flag_o, it.cyc, it.flag);
      end
    end
  end

  initial begin : watchdog
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam bit [27:0] EXT = 28'h800_0000;

  initial begin
    #12;
    n_chk++;
    if (idle_flag_o !== 1'b0) begin
      n_fail++; $display("FAIL R9 reset: flag=%0b expected 0", idle_flag_o);
    end
    rst_ni = 1;
    // R2: each nonseq code on set 0 (byte/half)
    for (int c = 0; c < 4; c++) begin
      nwait_i = 8'(c);
      step(EXT | 28'h100, 2'd1, 0, 1, 0, "R2 ncode");
      step(EXT | 28'h104, 2'd0, 0, 1, 0, "R2 ncode byte");
    end
    // R3: burst settings on every set
    nwait_i = 8'b10_01_00_11; // set3=2,set2=1,set1=0,set0=3
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 2; b++) begin
        swait_i = b ? 4'hF : 4'h0;
        step(EXT | (28'(k) << 25) | 28'h200, 2'd1, 1, 1, 0, "R3 seq set");
        step(EXT | (28'(k) << 25) | 28'h204, 2'd2, 1, 1, 0, "R4 seq word");
        step(EXT | (28'(k) << 25) | 28'h208, 2'd2, 0, 1, 0, "R4 nseq word");
      end
    end
    // R1: same low bits, internal vs external
    step(28'h200_0300, 2'd1, 1, 1, 0, "R1 internal");
    step(EXT | 28'h300, 2'd1, 1, 1, 0, "R1 external");
    // R5: page boundary forces nonseq; bit 0 alone still a page start
    swait_i = 4'h0;
    step(EXT | 28'h2_0000, 2'd1, 1, 1, 0, "R5 page");
    step(EXT | 28'h2_0001, 2'd2, 1, 1, 0, "R5 page word");
    step(EXT | 28'h2_0002, 2'd1, 1, 1, 0, "R5 not page");
    // R7 / R8: internal regions
    for (int w = 0; w < 16; w += 5) begin
      ram_wait_i = 4'(w);
      step(28'h200_0010, 2'd1, 0, 1, 0, "R7 ram half");
      step(28'h200_0010, 2'd2, 0, 1, 0, "R7 ram word");
    end
    for (int r = 0; r < 8; r++) begin
      step(28'(r) << 24, 2'd2, 1, 1, 0, "R8 region word");
      step(28'(r) << 24, 2'd0, 1, 1, 0, "R8 region byte");
    end
    // R9: internal idle ignored, external idle sets, flag forces nonseq (R6)
    step(28'h300_0000, 2'd1, 0, 0, 1, "R9 int idle");
    step(EXT | 28'h400, 2'd1, 1, 0, 0, "R9 no set");
    step(EXT | 28'h400, 2'd1, 1, 0, 1, "R9 ext idle");
    step(EXT | 28'h404, 2'd1, 1, 0, 0, "R9 hold");
    step(EXT | 28'h404, 2'd2, 1, 1, 0, "R6 flag nseq");
    step(EXT | 28'h408, 2'd2, 1, 1, 0, "R9 cleared");
    // R6 with page boundary together
    step(EXT | 28'h400, 2'd1, 1, 0, 1, "R9 set again");
    step(EXT | 28'h2_0000, 2'd1, 1, 1, 0, "R6 flag+page");
    // R10: idle and access together, flag low then high
    step(EXT | 28'h500, 2'd1, 1, 1, 1, "R10 both from low");
    step(EXT | 28'h504, 2'd1, 1, 0, 0, "R10 ends low");
    step(EXT | 28'h504, 2'd1, 1, 0, 1, "R10 prime");
    step(EXT | 28'h508, 2'd1, 1, 1, 1, "R10 both from high");
    step(EXT | 28'h50C, 2'd1, 1, 0, 0, "R10 ends low 2");
    @(negedge clk); #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule